// File: doc/BRIEF.md
# Equalizer Channel Boost and Standby Selector

This block settles, for each of four high-speed receive channels, the boost code that the analog equalizer stage is to use and whether the channel runs or sits in standby. Two kinds of source compete for each decision: board-level pins (a shared 3-bit boost bus, a pin that forces the pin boost onto every channel, and one enable pin per channel) and fields held in the configuration register file. The boost source and the enable source are chosen independently of each other. On the register side the per-channel control bit is a disable (1 = standby), while the pins are enables (1 = active).

Each channel is a small two-state machine (CH_STANDBY, CH_ACTIVE) that moves on the transition WAKE (standby to active when the selected source asks for activity) or SLEEP (active to standby when it does not), and otherwise stays put through HOLD. The boost code, the common output-level code and the channel states are all registered on the system clock, so any pin or register change shows at the outputs one edge later with no combinational path from the pins. A readback word repacks the effective settings in the same nibble layout as the per-channel configuration fields.

Top module: `eqsel_top`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, after that edge every channel is active, every boost code is 3'b100, `out_level` is 2'b10 and each status nibble is 4'b0100.
- R2: When `pin_force_ext` is 1, every channel's boost code becomes `pin_boost`; the per-channel boost fields in `cfg_fields` have no effect.
- R3: When `pin_force_ext` is 0, channel n's boost code becomes `cfg_fields[4n+2:4n]` (code 000 is weakest, 111 strongest).
- R4: When `cfg_reg_en_sel` is 0, channel n is active exactly when `pin_en[n]` is 1; the disable bit `cfg_fields[4n+3]` has no effect.
- R5: When `cfg_reg_en_sel` is 1, channel n is active exactly when `cfg_fields[4n+3]` is 0; `pin_en` has no effect.
- R6: `out_level` takes the 2-bit common output-level code `cfg_level` (00, 01, 10, 11 for the four amplitude steps, ascending).
- R7: All outputs are registered: values sampled at one rising edge appear right after that edge and do not move between edges when inputs change.
- R8: Status nibble n of `stat_fields` holds the effective boost of channel n in bits 4n+2:4n and the inverse of its active flag in bit 4n+3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pin_boost | input | 3 | Shared boost code from board pins |
| pin_force_ext | input | 1 | 1 = pin boost drives all channels |
| pin_en | input | 4 | Per-channel enable pins, 1 = active |
| cfg_fields | input | 16 | Per-channel nibble: bit 3 disable, bits 2:0 boost; channel n at bits 4n+3:4n |
| cfg_reg_en_sel | input | 1 | 1 = register disable bits choose the channel state |
| cfg_level | input | 2 | Common output-level code |
| eq_boost | output | 12 | Effective boost per channel, channel n at bits 3n+2:3n |
| ch_active | output | 4 | Per-channel active flag |
| out_level | output | 2 | Registered output-level code |
| stat_fields | output | 16 | Readback of effective boost and state in the cfg_fields layout |

## Verification
The assertions assume every input is synchronous to `clk`, held steady around each rising edge, and that reset is held low across at least one edge before release; their history checks only look back across edges where reset was already high. The bench changes inputs only on falling edges, except for one deliberate mid-cycle change that probes the register boundary and is then held until after the following edge. Stimulus sweeps all four combinations of boost source and enable source, drives pins against register bits to show the unselected source is inert, and pulses reset mid-run.

// File: rtl/eqsel_pkg.sv
package eqsel_pkg;

    typedef enum logic {
        CH_STANDBY = 1'b0,
        CH_ACTIVE  = 1'b1
    } ch_state_e;

    localparam int unsigned BOOST_W_DEF = 3;
    localparam int unsigned LEVEL_W_DEF = 2;

endpackage

// File: rtl/eqsel_src_sel.sv
module eqsel_src_sel #(
    parameter int unsigned BOOST_W = 3
) (
    input  logic               force_ext,
    input  logic [BOOST_W-1:0] pin_boost,
    input  logic [BOOST_W-1:0] reg_boost,
    input  logic               reg_mode,
    input  logic               pin_en,
    input  logic               reg_dis,
    output logic [BOOST_W-1:0] boost_sel,
    output logic               want_active
);

    always_comb begin
        boost_sel   = force_ext ? pin_boost : reg_boost;
        want_active = reg_mode ? ~reg_dis : pin_en;
    end

endmodule

// File: rtl/eqsel_chan_fsm.sv
module eqsel_chan_fsm
    import eqsel_pkg::*;
#(
    parameter int unsigned        BOOST_W   = 3,
    parameter logic [BOOST_W-1:0] BOOST_RST = 3'b100
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               want_active,
    input  logic [BOOST_W-1:0] boost_in,
    output logic               active_o,
    output logic [BOOST_W-1:0] boost_o
);

    ch_state_e state_q;
    ch_state_e state_d;

    // next-state: WAKE, SLEEP or HOLD
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CH_STANDBY: if (want_active)  state_d = CH_ACTIVE;
            CH_ACTIVE:  if (!want_active) state_d = CH_STANDBY;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= CH_ACTIVE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) boost_o <= BOOST_RST;
        else        boost_o <= boost_in;
    end

    assign active_o = (state_q == CH_ACTIVE);

endmodule

// File: rtl/eqsel_level_reg.sv
module eqsel_level_reg #(
    parameter int unsigned        LEVEL_W   = 2,
    parameter logic [LEVEL_W-1:0] LEVEL_RST = 2'b10
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [LEVEL_W-1:0] level_in,
    output logic [LEVEL_W-1:0] level_o
);

    always_ff @(posedge clk) begin
        if (!rst_n) level_o <= LEVEL_RST;
        else        level_o <= level_in;
    end

endmodule

// File: rtl/eqsel_top.sv
module eqsel_top
    import eqsel_pkg::*;
#(
    parameter int unsigned NUM_CH  = 4,
    parameter int unsigned BOOST_W = BOOST_W_DEF,
    parameter int unsigned LEVEL_W = LEVEL_W_DEF,
    localparam int unsigned FIELD_W = BOOST_W + 1,
    localparam int unsigned PACK_W  = NUM_CH * FIELD_W
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [BOOST_W-1:0]        pin_boost,
    input  logic                      pin_force_ext,
    input  logic [NUM_CH-1:0]         pin_en,
    input  logic [PACK_W-1:0]         cfg_fields,
    input  logic                      cfg_reg_en_sel,
    input  logic [LEVEL_W-1:0]        cfg_level,
    output logic [NUM_CH*BOOST_W-1:0] eq_boost,
    output logic [NUM_CH-1:0]         ch_active,
    output logic [LEVEL_W-1:0]        out_level,
    output logic [PACK_W-1:0]         stat_fields
);

    localparam logic [BOOST_W-1:0] BOOST_RST = BOOST_W'(1) << (BOOST_W - 1);
    localparam logic [LEVEL_W-1:0] LEVEL_RST = LEVEL_W'(1) << (LEVEL_W - 1);

    for (genvar n = 0; n < NUM_CH; n++) begin : g_ch
        logic [BOOST_W-1:0] boost_sel;
        logic               want_active;
        logic [BOOST_W-1:0] boost_q;
        logic               active_q;

        eqsel_src_sel #(.BOOST_W(BOOST_W)) u_sel (
            .force_ext   (pin_force_ext),
            .pin_boost   (pin_boost),
            .reg_boost   (cfg_fields[n*FIELD_W +: BOOST_W]),
            .reg_mode    (cfg_reg_en_sel),
            .pin_en      (pin_en[n]),
            .reg_dis     (cfg_fields[n*FIELD_W + BOOST_W]),
            .boost_sel   (boost_sel),
            .want_active (want_active)
        );

        eqsel_chan_fsm #(.BOOST_W(BOOST_W), .BOOST_RST(BOOST_RST)) u_fsm (
            .clk         (clk),
            .rst_n       (rst_n),
            .want_active (want_active),
            .boost_in    (boost_sel),
            .active_o    (active_q),
            .boost_o     (boost_q)
        );

        assign eq_boost[n*BOOST_W +: BOOST_W]     = boost_q;
        assign ch_active[n]                       = active_q;
        assign stat_fields[n*FIELD_W +: BOOST_W]  = boost_q;
        assign stat_fields[n*FIELD_W + BOOST_W]   = ~active_q;
    end

    eqsel_level_reg #(.LEVEL_W(LEVEL_W), .LEVEL_RST(LEVEL_RST)) u_level (
        .clk      (clk),
        .rst_n    (rst_n),
        .level_in (cfg_level),
        .level_o  (out_level)
    );

endmodule

// File: rtl/eqsel_chk.sv
module eqsel_chk #(
    parameter int unsigned NUM_CH  = 4,
    parameter int unsigned BOOST_W = 3,
    parameter int unsigned LEVEL_W = 2,
    localparam int unsigned FIELD_W = BOOST_W + 1,
    localparam int unsigned PACK_W  = NUM_CH * FIELD_W
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic [BOOST_W-1:0]        pin_boost,
    input logic                      pin_force_ext,
    input logic [NUM_CH-1:0]         pin_en,
    input logic [PACK_W-1:0]         cfg_fields,
    input logic                      cfg_reg_en_sel,
    input logic [LEVEL_W-1:0]        cfg_level,
    input logic [NUM_CH*BOOST_W-1:0] eq_boost,
    input logic [NUM_CH-1:0]         ch_active,
    input logic [LEVEL_W-1:0]        out_level,
    input logic [PACK_W-1:0]         stat_fields
);

    localparam logic [BOOST_W-1:0] BOOST_RST = BOOST_W'(1) << (BOOST_W - 1);
    localparam logic [LEVEL_W-1:0] LEVEL_RST = LEVEL_W'(1) << (LEVEL_W - 1);

    logic prev_in_rst;
    always_ff @(posedge clk) prev_in_rst <= !rst_n;

    always @(posedge clk) begin
        if (prev_in_rst == 1'b1) begin
            // R1
            reset_defaults_chk: assert (ch_active == {NUM_CH{1'b1}}
                                        && eq_boost == {NUM_CH{BOOST_RST}}
                                        && out_level == LEVEL_RST);
        end
    end

    // R6
    level_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> out_level == $past(cfg_level));

    for (genvar n = 0; n < NUM_CH; n++) begin : g_chk
        // R2
        boost_forced_chk: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(rst_n) && $past(pin_force_ext))
                |-> eq_boost[n*BOOST_W +: BOOST_W] == $past(pin_boost));

        // R3
        boost_field_chk: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(rst_n) && !$past(pin_force_ext))
                |-> eq_boost[n*BOOST_W +: BOOST_W] == $past(cfg_fields[n*FIELD_W +: BOOST_W]));

        // R4
        active_pin_chk: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(rst_n) && !$past(cfg_reg_en_sel))
                |-> ch_active[n] == $past(pin_en[n]));

        // R5
        active_reg_chk: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(rst_n) && $past(cfg_reg_en_sel))
                |-> ch_active[n] != $past(cfg_fields[n*FIELD_W + BOOST_W]));

        // R8
        stat_wake_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(ch_active[n]) |-> $fell(stat_fields[n*FIELD_W + BOOST_W]));
    end

endmodule

bind eqsel_top eqsel_chk #(
    .NUM_CH  (NUM_CH),
    .BOOST_W (BOOST_W),
    .LEVEL_W (LEVEL_W)
) u_chk (.*);

// File: tb/eqsel_top_bench.sv
module eqsel_top_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  pin_boost = 3'b100;
    logic        pin_force_ext = 1'b1;
    logic [3:0]  pin_en = 4'hF;
    logic [15:0] cfg_fields = 16'h4444;
    logic        cfg_reg_en_sel = 1'b0;
    logic [1:0]  cfg_level = 2'b10;
    logic [11:0] eq_boost;
    logic [3:0]  ch_active;
    logic [1:0]  out_level;
    logic [15:0] stat_fields;

    always #5 clk = ~clk;

    eqsel_top u_eqsel_top (
        .clk(clk), .rst_n(rst_n), .pin_boost(pin_boost), .pin_force_ext(pin_force_ext),
        .pin_en(pin_en), .cfg_fields(cfg_fields), .cfg_reg_en_sel(cfg_reg_en_sel),
        .cfg_level(cfg_level), .eq_boost(eq_boost), .ch_active(ch_active),
        .out_level(out_level), .stat_fields(stat_fields)
    );

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit done = 0;

    // behavioural reference, updated at each rising edge
    int exp_boost [4];
    int exp_act   [4];
    int exp_lvl;
    bit exp_valid = 0;
    bit exp_rst, exp_force, exp_regmode;

    task automatic check(input string tag, input int got, input int exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %0d expected %0d at %0t", tag, got, exp, $time);
        end
    endtask

    task automatic report();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int c = 0; c < 4; c++) begin
                exp_boost[c] = 4;
                exp_act[c]   = 1;
            end
            exp_lvl = 2;
            exp_rst = 1;
        end else begin
            for (int c = 0; c < 4; c++) begin
                if (pin_force_ext) exp_boost[c] = int'(pin_boost);
                else               exp_boost[c] = int'((cfg_fields >> (4*c)) & 16'h7);
                if (cfg_reg_en_sel) exp_act[c] = cfg_fields[4*c+3] ? 0 : 1;
                else                exp_act[c] = pin_en[c] ? 1 : 0;
            end
            exp_lvl = int'(cfg_level);
            exp_rst = 0;
        end
        exp_force   = pin_force_ext;
        exp_regmode = cfg_reg_en_sel;
        exp_valid   = 1;
    end

    always @(negedge clk) begin
        if (exp_valid && !done) begin
            for (int c = 0; c < 4; c++) begin
                check(exp_rst ? "R1 boost" : (exp_force ? "R2 boost" : "R3 boost"),
                      int'(eq_boost[3*c +: 3]), exp_boost[c]);
                check(exp_rst ? "R1 active" : (exp_regmode ? "R5 active" : "R4 active"),
                      int'(ch_active[c]), exp_act[c]);
                check("R8 status boost", int'(stat_fields[4*c +: 3]), exp_boost[c]);
                check("R8 status disable", int'(stat_fields[4*c+3]), 1 - exp_act[c]);
            end
            check(exp_rst ? "R1 level" : "R6 level", int'(out_level), exp_lvl);
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000 && !done) begin
            errors++;
            $display("FAIL watchdog: got %0d cycles expected at most 20000", cycles);
            report();
        end
    end

    task automatic drive(input logic [2:0] b, input logic f, input logic [3:0] e,
                         input logic [15:0] cf, input logic rs, input logic [1:0] lv);
        @(negedge clk);
        pin_boost = b; pin_force_ext = f; pin_en = e;
        cfg_fields = cf; cfg_reg_en_sel = rs; cfg_level = lv;
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        // R2: forced pins, register boost fields differ and are ignored
        drive(3'b000, 1'b1, 4'hF, 16'h7777, 1'b0, 2'b00);
        drive(3'b111, 1'b1, 4'hF, 16'h0000, 1'b0, 2'b01);
        // R3: per-channel fields
        drive(3'b000, 1'b0, 4'hF, 16'h7531, 1'b0, 2'b11);
        drive(3'b111, 1'b0, 4'hF, 16'h0246, 1'b0, 2'b10);
        // R4: pin enables, register disable bits set but ignored
        drive(3'b011, 1'b0, 4'b0101, 16'hF8F8, 1'b0, 2'b00);
        drive(3'b011, 1'b1, 4'b1010, 16'h8888, 1'b0, 2'b01);
        // R5: register disables, pins opposite and ignored
        drive(3'b101, 1'b1, 4'b0000, 16'h0000, 1'b1, 2'b10);
        drive(3'b101, 1'b0, 4'b1111, 16'h8F08, 1'b1, 2'b11);
        drive(3'b101, 1'b0, 4'b0110, 16'hFFFF, 1'b1, 2'b00);
        drive(3'b101, 1'b0, 4'b0110, 16'hFFFF, 1'b1, 2'b00);
        // R7: mid-cycle change must not reach outputs before the next edge
        @(posedge clk);
        #1 pin_boost = 3'b010; pin_force_ext = 1'b1; pin_en = 4'h0; cfg_reg_en_sel = 1'b0;
        cfg_level = 2'b01;
        #2;
        check("R7 boost hold", int'(eq_boost[2:0]), 7);
        check("R7 active hold", int'(ch_active), 0);
        check("R7 level hold", int'(out_level), 0);
        repeat (2) @(negedge clk);
        // R1: reset mid-run
        drive(3'b001, 1'b0, 4'h0, 16'hFFFF, 1'b1, 2'b00);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // mixed random patterns over all source combinations
        for (int i = 0; i < 3000; i++) begin
            drive(3'($urandom), 1'($urandom), 4'($urandom), 16'($urandom),
                  1'($urandom), 2'($urandom));
        end
        repeat (3) @(negedge clk);
        done = 1;
        report();
    end

endmodule